// File: doc/BRIEF.md
# Cell Fault Flag and Interrupt Unit

This block watches the conversion results of a twelve-channel battery cell monitor and turns them into per-cell fault flags. Each time a new 12-bit code arrives for a cell, it is compared with a programmable low limit and a programmable high limit. The result raises or clears that cell's undervoltage and overvoltage flags. Codes use an offset encoding: 512 stands for zero volts and each step is 1.5 mV. The limits are held in the same encoding, so no scaling happens here.

Each cell has a mask bit. A set mask bit silences that cell's interrupt and also holds both of its flags at zero. A single interrupt line is high while any unmasked flag is set. A sticky thermal status bit is set by an event input and is cleared when software reads it. The last result of each cell is kept in a small RAM. A registered read port returns results, flag vectors, the thermal bit and the masks. While a conversion round is in progress, every result address reads as all ones.

Top module: `cell_fault_unit`

## Requirements
- R1: After a synchronous reset, all flags, all mask bits, the thermal bit and `irq_o` are 0, and every result address reads 0 until its cell is written.
- R2: On a result for cell i, the undervoltage flag i becomes 1 if the code is strictly below the low limit and 0 otherwise, in the clock edge that accepts the result.
- R3: On a result for cell i, the overvoltage flag i becomes 1 if the code is strictly above the high limit and 0 otherwise, in the same edge.
- R4: Writing 1 to mask bit i clears both flags of cell i at that edge and holds them at 0 while the bit stays 1, whatever results arrive. Clearing the bit does not restore a flag until a new result arrives.
- R5: `irq_o` is 1 exactly when some unmasked flag is set, and it changes at the same edge as the flags.
- R6: A read issued with `rd_en` returns data on `rd_data_o`, with `rd_valid_o` high, two clock edges later. A result address returns the last code written to that cell.
- R7: Between a `conv_start` pulse and the following `conv_done` pulse, result addresses read 0xFFF. Flag, mask and thermal reads are unaffected. If both pulses arrive together, start wins.
- R8: `therm_evt` sets the thermal bit, which stays set until a read of the thermal address. That read returns the value held before the read, then clears the bit. An event in the same cycle as the read leaves the bit set.
- R9: Read address map, with N = 12: addresses 0..N-1 hold the cell results. N holds the undervoltage flags, with bit i for cell i. N+1 holds the overvoltage flags. N+2 holds the thermal bit in bit 0. N+3 holds the masks. Configuration select values are 0 for the low limit, 1 for the high limit and 2 for the masks; the value is taken from `cfg_wdata`.
- R10: A result whose index is N or above is ignored: no flag and no stored result changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 low limit, 1 high limit, 2 masks |
| cfg_wdata | input | 16 | Configuration write value |
| conv_start | input | 1 | Marks the start of a conversion round |
| conv_done | input | 1 | Marks the end of a conversion round |
| res_valid | input | 1 | New conversion result present |
| res_idx | input | 4 | Cell index of the result |
| res_data | input | 12 | 12-bit result code |
| therm_evt | input | 1 | Thermal shutdown event |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 16 | Read data, zero-extended |
| irq_o | output | 1 | Interrupt pending |

## Verification
On every cycle, the checker enforces several properties:
- a masked cell never carries a flag;
- the interrupt line always equals the OR of the flag vectors;
- each accepted result sets or clears its flags against the limits;
- the thermal bit never drops without a read;
- reads during a conversion round return all ones.

Other behaviours need the bench's scenarios:
- a cleared mask does not bring a flag back;
- flags are re-evaluated on a later result;
- values equal to a limit do not flag;
- out-of-range indices are ignored;
- the exact cycle ordering of a thermal read against a coinciding event.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef enum logic [1:0] {
    CFG_LO_LIM = 2'd0,
    CFG_HI_LIM = 2'd1,
    CFG_MASK   = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_sel_e;

  typedef enum logic [2:0] {
    RK_RESULT = 3'd0,
    RK_UV     = 3'd1,
    RK_OV     = 3'd2,
    RK_THERM  = 3'd3,
    RK_MASK   = 3'd4,
    RK_NONE   = 3'd5
  } rd_kind_e;
endpackage

// File: rtl/cfu_cfg_regs.sv
module cfu_cfg_regs #(
  parameter int NUM_CELLS = 12,
  parameter int CODE_W    = 12,
  parameter int REG_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [REG_W-1:0]     cfg_wdata,
  output logic [CODE_W-1:0]    lo_lim_q,
  output logic [CODE_W-1:0]    hi_lim_q,
  output logic [NUM_CELLS-1:0] mask_q,
  output logic [NUM_CELLS-1:0] mask_nxt
);
  import cfu_pkg::*;

  logic [REG_W-1:0] unused_hi;
  assign unused_hi = cfg_wdata;

  // next mask value goes to the flag bank so masking and clearing share an edge
  always_comb begin
    mask_nxt = mask_q;
    if (cfg_we && cfg_sel_e'(cfg_sel) == CFG_MASK)
      mask_nxt = cfg_wdata[NUM_CELLS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_lim_q <= '0;
      hi_lim_q <= '1;
      mask_q   <= '0;
    end else begin
      mask_q <= mask_nxt;
      if (cfg_we && cfg_sel_e'(cfg_sel) == CFG_LO_LIM) lo_lim_q <= cfg_wdata[CODE_W-1:0];
      if (cfg_we && cfg_sel_e'(cfg_sel) == CFG_HI_LIM) hi_lim_q <= cfg_wdata[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/cfu_flag_bank.sv
module cfu_flag_bank #(
  parameter int NUM_CELLS = 12,
  parameter int CODE_W    = 12,
  localparam int IDX_W    = $clog2(NUM_CELLS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [CODE_W-1:0]    wr_data,
  input  logic [CODE_W-1:0]    lo_lim,
  input  logic [CODE_W-1:0]    hi_lim,
  input  logic [NUM_CELLS-1:0] mask_nxt,
  output logic [NUM_CELLS-1:0] uv_q,
  output logic [NUM_CELLS-1:0] ov_q,
  output logic                 irq_q
);
  logic [NUM_CELLS-1:0] hit;
  logic [NUM_CELLS-1:0] uv_d;
  logic [NUM_CELLS-1:0] ov_d;
  logic                 below;
  logic                 above;

  assign below = wr_data < lo_lim;
  assign above = wr_data > hi_lim;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    assign hit[i]  = wr_en && (wr_idx == IDX_W'(i));
    assign uv_d[i] = mask_nxt[i] ? 1'b0 : (hit[i] ? below : uv_q[i]);
    assign ov_d[i] = mask_nxt[i] ? 1'b0 : (hit[i] ? above : ov_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_q  <= '0;
      ov_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      uv_q  <= uv_d;
      ov_q  <= ov_d;
      irq_q <= |(uv_d | ov_d);
    end
  end
endmodule

// File: rtl/cfu_result_store.sv
module cfu_result_store #(
  parameter int NUM_CELLS = 12,
  parameter int CODE_W    = 12,
  localparam int IDX_W    = $clog2(NUM_CELLS),
  localparam int DEPTH    = 2 ** IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CODE_W-1:0] rd_q,
  output logic [DEPTH-1:0]  valid_q,
  output logic              busy_q
);
  logic [CODE_W-1:0] mem [DEPTH];

  // plain RAM: no reset on contents, registered read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_q <= mem[rd_idx];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_valid
    always_ff @(posedge clk) begin
      if (rst) valid_q[i] <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(i)) valid_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             busy_q <= 1'b0;
    else if (conv_start) busy_q <= 1'b1;
    else if (conv_done)  busy_q <= 1'b0;
  end
endmodule

// File: rtl/cell_fault_unit.sv
module cell_fault_unit #(
  parameter int NUM_CELLS = 12,
  parameter int CODE_W    = 12,
  parameter int REG_W     = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [1:0]                      cfg_sel,
  input  logic [REG_W-1:0]                cfg_wdata,
  input  logic                            conv_start,
  input  logic                            conv_done,
  input  logic                            res_valid,
  input  logic [$clog2(NUM_CELLS)-1:0]    res_idx,
  input  logic [CODE_W-1:0]               res_data,
  input  logic                            therm_evt,
  input  logic                            rd_en,
  input  logic [$clog2(NUM_CELLS+4)-1:0]  rd_addr,
  output logic                            rd_valid_o,
  output logic [REG_W-1:0]                rd_data_o,
  output logic                            irq_o
);
  import cfu_pkg::*;

  localparam int IDX_W   = $clog2(NUM_CELLS);
  localparam int ADDR_W  = $clog2(NUM_CELLS + 4);
  localparam int DEPTH   = 2 ** IDX_W;
  localparam int A_UV    = NUM_CELLS;
  localparam int A_OV    = NUM_CELLS + 1;
  localparam int A_THERM = NUM_CELLS + 2;
  localparam int A_MASK  = NUM_CELLS + 3;

  logic [CODE_W-1:0]    lo_lim, hi_lim;
  logic [NUM_CELLS-1:0] mask_q, mask_nxt;
  logic [NUM_CELLS-1:0] uv_flags, ov_flags;
  logic                 irq_q;
  logic                 res_ok;
  logic [CODE_W-1:0]    ram_q;
  logic [DEPTH-1:0]     cell_valid;
  logic                 busy_q;
  logic                 therm_q;
  rd_kind_e             rd_kind;

  assign res_ok = res_valid && (int'(res_idx) < NUM_CELLS);

  cfu_cfg_regs #(.NUM_CELLS(NUM_CELLS), .CODE_W(CODE_W), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .lo_lim_q(lo_lim), .hi_lim_q(hi_lim), .mask_q(mask_q), .mask_nxt(mask_nxt)
  );

  cfu_flag_bank #(.NUM_CELLS(NUM_CELLS), .CODE_W(CODE_W)) u_flags (
    .clk(clk), .rst(rst), .wr_en(res_ok), .wr_idx(res_idx), .wr_data(res_data),
    .lo_lim(lo_lim), .hi_lim(hi_lim), .mask_nxt(mask_nxt),
    .uv_q(uv_flags), .ov_q(ov_flags), .irq_q(irq_q)
  );

  cfu_result_store #(.NUM_CELLS(NUM_CELLS), .CODE_W(CODE_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(res_ok), .wr_idx(res_idx), .wr_data(res_data),
    .conv_start(conv_start), .conv_done(conv_done),
    .rd_en(rd_en), .rd_idx(rd_addr[IDX_W-1:0]),
    .rd_q(ram_q), .valid_q(cell_valid), .busy_q(busy_q)
  );

  // address decode
  always_comb begin
    if (int'(rd_addr) < NUM_CELLS)   rd_kind = RK_RESULT;
    else if (int'(rd_addr) == A_UV)    rd_kind = RK_UV;
    else if (int'(rd_addr) == A_OV)    rd_kind = RK_OV;
    else if (int'(rd_addr) == A_THERM) rd_kind = RK_THERM;
    else if (int'(rd_addr) == A_MASK)  rd_kind = RK_MASK;
    else                               rd_kind = RK_NONE;
  end

  // sticky thermal status, set beats read-clear
  always_ff @(posedge clk) begin
    if (rst) therm_q <= 1'b0;
    else     therm_q <= therm_evt | (therm_q & ~(rd_en && rd_kind == RK_THERM));
  end

  // read stage 1: snapshot alongside the RAM read
  logic                 s1_vld;
  rd_kind_e             s1_kind;
  logic                 s1_busy, s1_cv, s1_therm;
  logic [NUM_CELLS-1:0] s1_uv, s1_ov, s1_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_kind  <= RK_NONE;
      s1_busy  <= 1'b0;
      s1_cv    <= 1'b0;
      s1_therm <= 1'b0;
      s1_uv    <= '0;
      s1_ov    <= '0;
      s1_mask  <= '0;
    end else begin
      s1_vld <= rd_en;
      if (rd_en) begin
        s1_kind  <= rd_kind;
        s1_busy  <= busy_q;
        s1_cv    <= cell_valid[rd_addr[IDX_W-1:0]];
        s1_therm <= therm_q;
        s1_uv    <= uv_flags;
        s1_ov    <= ov_flags;
        s1_mask  <= mask_q;
      end
    end
  end

  // read stage 2: registered output mux
  logic [REG_W-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    unique case (s1_kind)
      RK_RESULT: rd_d[CODE_W-1:0] = s1_busy ? {CODE_W{1'b1}} : (s1_cv ? ram_q : '0);
      RK_UV:     rd_d[NUM_CELLS-1:0] = s1_uv;
      RK_OV:     rd_d[NUM_CELLS-1:0] = s1_ov;
      RK_THERM:  rd_d[0] = s1_therm;
      RK_MASK:   rd_d[NUM_CELLS-1:0] = s1_mask;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= s1_vld;
      if (s1_vld) rd_data_o <= rd_d;
    end
  end

  assign irq_o = irq_q;

  logic [ADDR_W-1:0] unused_addr;
  assign unused_addr = rd_addr;
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
  parameter int NUM_CELLS = 12,
  parameter int CODE_W    = 12,
  parameter int REG_W     = 16
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           res_valid,
  input logic [$clog2(NUM_CELLS)-1:0]   res_idx,
  input logic [CODE_W-1:0]              res_data,
  input logic                           rd_en,
  input logic [$clog2(NUM_CELLS+4)-1:0] rd_addr,
  input logic                           rd_valid_o,
  input logic [REG_W-1:0]               rd_data_o,
  input logic                           irq_o,
  input logic [NUM_CELLS-1:0]           uv_q,
  input logic [NUM_CELLS-1:0]           ov_q,
  input logic [NUM_CELLS-1:0]           mask_q,
  input logic [CODE_W-1:0]              lo_lim,
  input logic [CODE_W-1:0]              hi_lim,
  input logic                           therm_q,
  input logic                           busy_q
);
  logic [NUM_CELLS-1:0] sel_oh;
  logic                 in_rng;
  logic                 therm_rd;

  always_comb begin
    for (int i = 0; i < NUM_CELLS; i++) sel_oh[i] = (int'(res_idx) == i);
  end
  assign in_rng   = res_valid && (int'(res_idx) < NUM_CELLS);
  assign therm_rd = rd_en && (int'(rd_addr) == NUM_CELLS + 2);

  assert_mask_clears_R4: assert property (@(posedge clk) disable iff (rst)
    ((uv_q | ov_q) & mask_q) == '0);

  assert_irq_matches_R5: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(uv_q | ov_q));

  assert_uv_set_R2: assert property (@(posedge clk) disable iff (rst)
    (in_rng && res_data < lo_lim) |=> (($past(sel_oh) & (uv_q | mask_q)) != '0));

  assert_uv_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (in_rng && res_data >= lo_lim) |=> (($past(sel_oh) & uv_q) == '0));

  assert_ov_set_R3: assert property (@(posedge clk) disable iff (rst)
    (in_rng && res_data > hi_lim) |=> (($past(sel_oh) & (ov_q | mask_q)) != '0));

  assert_ov_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (in_rng && res_data <= hi_lim) |=> (($past(sel_oh) & ov_q) == '0));

  assert_therm_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (therm_q && !therm_rd) |=> therm_q);

  assert_busy_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(rd_addr) < NUM_CELLS && busy_q) |-> ##2 (rd_data_o[CODE_W-1:0] == {CODE_W{1'b1}}));

  assert_read_latency_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ##2 rd_valid_o);
endmodule

bind cell_fault_unit cfu_checker #(.NUM_CELLS(NUM_CELLS), .CODE_W(CODE_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
  .irq_o(irq_o), .uv_q(uv_flags), .ov_q(ov_flags), .mask_q(mask_q),
  .lo_lim(lo_lim), .hi_lim(hi_lim), .therm_q(therm_q), .busy_q(busy_q)
);

// File: tb/cell_fault_unit_tb.sv
module cell_fault_unit_tb;
  localparam int N = 12;
  localparam int A_UV = N, A_OV = N + 1, A_TH = N + 2, A_MK = N + 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [15:0] cfg_wdata = '0;
  logic        conv_start = 1'b0, conv_done = 1'b0;
  logic        res_valid = 1'b0;
  logic [3:0]  res_idx = '0;
  logic [11:0] res_data = '0;
  logic        therm_evt = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic        rd_valid_o, irq_o;
  logic [15:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cell_fault_unit u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .conv_start(conv_start), .conv_done(conv_done), .res_valid(res_valid),
    .res_idx(res_idx), .res_data(res_data), .therm_evt(therm_evt),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic put_result(logic [3:0] idx, logic [11:0] val);
    @(negedge clk);
    res_valid = 1'b1; res_idx = idx; res_data = val;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic pulse_start(); @(negedge clk); conv_start = 1'b1; @(negedge clk); conv_start = 1'b0; endtask
  task automatic pulse_done();  @(negedge clk); conv_done = 1'b1;  @(negedge clk); conv_done = 1'b0;  endtask

  task automatic read_reg(logic [3:0] addr, output logic [15:0] val);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = addr;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    chk("R6 valid", 32'(rd_valid_o), 32'd1);
    val = rd_data_o;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    read_reg(4'(A_UV), v); chk("R1 uv", 32'(v), 32'h0);
    read_reg(4'(A_OV), v); chk("R1 ov", 32'(v), 32'h0);
    read_reg(4'(A_TH), v); chk("R1 therm", 32'(v), 32'h0);
    read_reg(4'(A_MK), v); chk("R1 mask", 32'(v), 32'h0);
    read_reg(4'd5, v);     chk("R1 result", 32'(v), 32'h0);
    chk("R1 irq", 32'(irq_o), 32'd0);
  endtask

  task automatic t_limits();
    logic [15:0] v;
    cfg_write(2'd0, 16'd1000);
    cfg_write(2'd1, 16'd3000);
    put_result(4'd0, 12'd999);
    chk("R5 irq rises", 32'(irq_o), 32'd1);
    put_result(4'd1, 12'd1000);
    put_result(4'd2, 12'd3001);
    put_result(4'd3, 12'd3000);
    read_reg(4'(A_UV), v); chk("R2 uv below and equal", 32'(v), 32'h001);
    read_reg(4'(A_OV), v); chk("R3 ov above and equal", 32'(v), 32'h004);
    put_result(4'd0, 12'd2000);
    read_reg(4'(A_UV), v); chk("R2 uv reevaluated", 32'(v), 32'h000);
    chk("R5 irq from ov", 32'(irq_o), 32'd1);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    cfg_write(2'd2, 16'h004);
    read_reg(4'(A_OV), v); chk("R4 mask clears ov", 32'(v), 32'h000);
    chk("R5 irq low when masked", 32'(irq_o), 32'd0);
    put_result(4'd2, 12'd4000);
    read_reg(4'(A_OV), v); chk("R4 held clear", 32'(v), 32'h000);
    read_reg(4'(A_MK), v); chk("R9 mask readback", 32'(v), 32'h004);
    cfg_write(2'd2, 16'h000);
    read_reg(4'(A_OV), v); chk("R4 unmask no restore", 32'(v), 32'h000);
    put_result(4'd2, 12'd4000);
    read_reg(4'(A_OV), v); chk("R3 ov after unmask", 32'(v), 32'h004);
    chk("R5 irq back", 32'(irq_o), 32'd1);
  endtask

  task automatic t_results();
    logic [15:0] v;
    put_result(4'd11, 12'hABC);
    read_reg(4'd11, v); chk("R6 result cell11", 32'(v), 32'hABC);
    read_reg(4'd1, v);  chk("R6 result cell1", 32'(v), 32'd1000);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    pulse_start();
    read_reg(4'd1, v);     chk("R7 busy reads ones", 32'(v), 32'hFFF);
    read_reg(4'(A_OV), v); chk("R7 flags during busy", 32'(v), 32'h004);
    @(negedge clk); conv_start = 1'b1; conv_done = 1'b1;
    @(negedge clk); conv_start = 1'b0; conv_done = 1'b0;
    read_reg(4'd1, v);     chk("R7 start beats done", 32'(v), 32'hFFF);
    pulse_done();
    read_reg(4'd1, v);     chk("R7 after done", 32'(v), 32'd1000);
  endtask

  task automatic t_bad_index();
    logic [15:0] v;
    put_result(4'd12, 12'd0);
    put_result(4'd15, 12'hFFF);
    read_reg(4'(A_UV), v); chk("R10 uv unchanged", 32'(v), 32'h000);
    read_reg(4'(A_OV), v); chk("R10 ov unchanged", 32'(v), 32'h004);
    read_reg(4'd0, v);     chk("R10 cell0 unchanged", 32'(v), 32'd2000);
  endtask

  task automatic t_thermal();
    logic [15:0] v;
    @(negedge clk); therm_evt = 1'b1; @(negedge clk); therm_evt = 1'b0;
    repeat (3) @(negedge clk);
    read_reg(4'(A_TH), v); chk("R8 sticky read", 32'(v), 32'h1);
    read_reg(4'(A_TH), v); chk("R8 cleared by read", 32'(v), 32'h0);
    @(negedge clk); rd_en = 1'b1; rd_addr = 4'(A_TH); therm_evt = 1'b1;
    @(negedge clk); rd_en = 1'b0; therm_evt = 1'b0;
    @(negedge clk); chk("R8 old value on coinciding read", 32'(rd_data_o), 32'h0);
    read_reg(4'(A_TH), v); chk("R8 event wins over clear", 32'(v), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_limits();
    t_mask();
    t_results();
    t_busy();
    t_bad_index();
    t_thermal();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule